// File: doc/BRIEF.md
# Coherent Accelerator Request Router

This block sits between an accelerator's slave port and the rest of a multi-processor cluster. It takes read and write address requests, with attributes in the AXI3 style, and decides for each one whether the processor caches must be consulted. That decision uses one bit of the request's user sideband and the shareable/modifiable bit of its cache attribute. Requests that need coherence go first to a simplified snoop interface. Everything else goes straight to one of several downstream master ports.

A coherent read that hits in a processor cache is answered from the snoop data and never reaches a master port. A coherent write that hits waits until the processor has cleaned and invalidated the line, and only then goes downstream. Misses, and requests that are not coherent, are forwarded unchanged except that the lock attribute is always cleared. Each channel chooses its master port in round-robin order, and it skips a stalled port when the other port can take the request.

Top module: `cohport_router`

## Requirements
- R1: While reset is held, every valid output (s_rvalid, snp_rd_valid, snp_wr_valid, m_arvalid, m_awvalid) is low and s_arready and s_awready are low. After reset is released, both readies go high.
- R2: A read is coherent exactly when s_aruser bit 0 is 1 and s_arcache bit 1 is 1. A coherent read raises snp_rd_valid once, with snp_rd_addr equal to the request address.
- R3: A read that is not coherent makes no snoop request and is forwarded to a master port.
- R4: When a coherent read's snoop response has hit set, the snoop data appears on s_rdata with s_rid equal to the request ID and s_rresp = 2'b00. No master port sees the read. s_rvalid and s_rdata stay unchanged until s_rready is high.
- R5: A forwarded read (a non-coherent read or a snoop miss) presents the request's address, ID, length, size, burst, cache and protection values unchanged on the m_ar* outputs, with m_arlock = 0.
- R6: A write is coherent exactly when s_awuser bit 0 is 1 and s_awcache bit 1 is 1. A coherent write raises snp_wr_valid with the request address. A write that is not coherent makes no snoop request.
- R7: After a write snoop response with hit set, m_awvalid stays low until a snp_wr_done pulse has been seen. After that pulse the write is forwarded.
- R8: A forwarded write (non-coherent, snoop miss, or after the clean) presents the request's address, ID, length, size, burst, cache and protection unchanged on the m_aw* outputs, with m_awlock = 0.
- R9: Each channel holds one request at a time. Its ready is low from the cycle after acceptance until the cycle after the read data handshake or the downstream handshake.
- R10: When every master port is ready, each channel sends successive forwarded requests to ports 0, 1, 0, 1, ... It starts at port 0 after reset.
- R11: The port is fixed in the cycle the request becomes ready to forward. If the preferred port's ready is low and another port's ready is high, the first ready port after it in circular order is used. The next preference is the port after the one used. If no port is ready, the preferred port is used.
- R12: At most one bit of m_arvalid is set at a time, and the same holds for m_awvalid. A forwarded valid stays on the same port, with its address unchanged, until that port's ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_arvalid | input | 1 | Read request valid |
| s_arready | output | 1 | Read request accepted |
| s_araddr | input | ADDR_W | Read address |
| s_arid | input | ID_W | Read ID |
| s_arlen | input | 4 | Read burst length |
| s_arsize | input | 3 | Read beat size |
| s_arburst | input | 2 | Read burst type |
| s_arcache | input | 4 | Read cache attribute (bit 1 used for coherence) |
| s_arprot | input | 3 | Read protection |
| s_arlock | input | 1 | Read lock attribute |
| s_aruser | input | USER_W | Read user sideband (bit COH_USER_BIT used for coherence) |
| s_rvalid | output | 1 | Read data from a snoop hit is valid |
| s_rready | input | 1 | Read data accepted |
| s_rdata | output | DATA_W | Read data |
| s_rid | output | ID_W | Read data ID |
| s_rresp | output | 2 | Read response, always OKAY |
| s_awvalid | input | 1 | Write request valid |
| s_awready | output | 1 | Write request accepted |
| s_awaddr | input | ADDR_W | Write address |
| s_awid | input | ID_W | Write ID |
| s_awlen | input | 4 | Write burst length |
| s_awsize | input | 3 | Write beat size |
| s_awburst | input | 2 | Write burst type |
| s_awcache | input | 4 | Write cache attribute (bit 1 used for coherence) |
| s_awprot | input | 3 | Write protection |
| s_awlock | input | 1 | Write lock attribute |
| s_awuser | input | USER_W | Write user sideband |
| snp_rd_valid | output | 1 | Read snoop request |
| snp_rd_ready | input | 1 | Read snoop request accepted |
| snp_rd_addr | output | ADDR_W | Read snoop address |
| snp_rd_rsp_valid | input | 1 | Read snoop response pulse |
| snp_rd_rsp_hit | input | 1 | Read snoop hit |
| snp_rd_rsp_data | input | DATA_W | Read snoop data |
| snp_wr_valid | output | 1 | Write snoop request |
| snp_wr_ready | input | 1 | Write snoop request accepted |
| snp_wr_addr | output | ADDR_W | Write snoop address |
| snp_wr_rsp_valid | input | 1 | Write snoop response pulse |
| snp_wr_rsp_hit | input | 1 | Write snoop hit |
| snp_wr_done | input | 1 | Clean-and-invalidate complete pulse |
| m_arvalid | output | NPORT | Per-port read valid |
| m_arready | input | NPORT | Per-port read ready |
| m_araddr | output | ADDR_W | Forwarded read address |
| m_arid | output | ID_W | Forwarded read ID |
| m_arlen | output | 4 | Forwarded read length |
| m_arsize | output | 3 | Forwarded read size |
| m_arburst | output | 2 | Forwarded read burst |
| m_arcache | output | 4 | Forwarded read cache |
| m_arprot | output | 3 | Forwarded read protection |
| m_arlock | output | 1 | Forwarded read lock, cleared |
| m_awvalid | output | NPORT | Per-port write valid |
| m_awready | input | NPORT | Per-port write ready |
| m_awaddr | output | ADDR_W | Forwarded write address |
| m_awid | output | ID_W | Forwarded write ID |
| m_awlen | output | 4 | Forwarded write length |
| m_awsize | output | 3 | Forwarded write size |
| m_awburst | output | 2 | Forwarded write burst |
| m_awcache | output | 4 | Forwarded write cache |
| m_awprot | output | 3 | Forwarded write protection |
| m_awlock | output | 1 | Forwarded write lock, cleared |

## Verification
The bench builds the router with two master ports, a 16-bit address, a 3-bit ID, a 1-bit user field and 32-bit data. That configuration is small enough to sweep every combination of the user bit and the four cache bits on both channels, with snoop hit and miss tied to cache bit 0. The sweep therefore covers every classification case and every hit or miss path. With two ports, the round-robin order can be predicted arithmetically. Fixed ready patterns on one port, on the other, and on neither reach the skip rule, the fallback to the preferred port, and the rule that a stalled valid is held.

// File: rtl/cohport_pkg.sv
package cohport_pkg;

   typedef struct packed {
      logic [3:0] len;
      logic [2:0] size;
      logic [1:0] burst;
      logic [3:0] cache;
      logic [2:0] prot;
      logic       lock;
   } axi_attr_t;

   typedef enum logic [2:0] {
      CH_IDLE,
      CH_SNOOP,
      CH_WAIT,
      CH_CLEAN,
      CH_RET,
      CH_FWD
   } ch_state_e;

   localparam int CACHE_SHARE_BIT = 1;

endpackage

// File: rtl/cohport_classify.sv
module cohport_classify (
   input  logic user_bit,
   input  logic share_bit,
   output logic coherent
);
   assign coherent = user_bit & share_bit;
endmodule

// File: rtl/cohport_port_pick.sv
module cohport_port_pick #(
   parameter int NPORT = 2,
   localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] ready,
   input  logic             pick,
   input  logic             grant_done,
   output logic [SEL_W-1:0] sel
);
   logic [SEL_W-1:0] ptr;
   logic [SEL_W-1:0] cand;

   if (NPORT < 2) begin : g_np_chk
      $error("cohport_port_pick needs at least two ports");
   end

   always_comb begin
      logic found;
      int   idx;
      cand  = ptr;
      found = 1'b0;
      for (int k = 0; k < NPORT; k++) begin
         idx = (int'(ptr) + k) % NPORT;
         if (!found && ready[idx]) begin
            cand  = SEL_W'(idx);
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         sel <= '0;
      end else begin
         if (pick)
            sel <= cand;
         if (grant_done)
            ptr <= (int'(sel) == NPORT - 1) ? '0 : sel + 1'b1;
      end
   end
endmodule

// File: rtl/cohport_rd_chan.sv
module cohport_rd_chan
   import cohport_pkg::*;
#(
   parameter int NPORT  = 2,
   parameter int ADDR_W = 32,
   parameter int ID_W   = 4,
   parameter int DATA_W = 32,
   localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [ID_W-1:0]   s_id,
   input  axi_attr_t         s_attr,
   input  logic              s_coh_user,
   output logic              ret_valid,
   input  logic              ret_ready,
   output logic [DATA_W-1:0] ret_data,
   output logic [ID_W-1:0]   ret_id,
   output logic              snp_valid,
   input  logic              snp_ready,
   output logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_rsp_valid,
   input  logic              snp_rsp_hit,
   input  logic [DATA_W-1:0] snp_rsp_data,
   output logic [NPORT-1:0]  m_valid,
   input  logic [NPORT-1:0]  m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic [ID_W-1:0]   m_id,
   output axi_attr_t         m_attr
);
   ch_state_e        st;
   logic             en;
   logic             coh;
   logic             pick;
   logic             grant_done;
   logic [SEL_W-1:0] sel;
   logic             accept;

   cohport_classify u_cls (
      .user_bit (s_coh_user),
      .share_bit(s_attr.cache[CACHE_SHARE_BIT]),
      .coherent (coh)
   );

   cohport_port_pick #(.NPORT(NPORT)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (m_ready),
      .pick      (pick),
      .grant_done(grant_done),
      .sel       (sel)
   );

   assign accept     = s_valid && s_ready;
   assign pick       = (accept && !coh) ||
                       (st == CH_WAIT && snp_rsp_valid && !snp_rsp_hit);
   assign grant_done = (st == CH_FWD) && m_ready[sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= CH_IDLE;
         en       <= 1'b0;
         m_addr   <= '0;
         m_id     <= '0;
         m_attr   <= '0;
         ret_data <= '0;
      end else begin
         en <= 1'b1;
         unique case (st)
            CH_IDLE: if (accept) begin
               m_addr      <= s_addr;
               m_id        <= s_id;
               m_attr      <= s_attr;
               m_attr.lock <= 1'b0;
               st          <= coh ? CH_SNOOP : CH_FWD;
            end
            CH_SNOOP: if (snp_ready) st <= CH_WAIT;
            CH_WAIT: if (snp_rsp_valid) begin
               if (snp_rsp_hit) begin
                  ret_data <= snp_rsp_data;
                  st       <= CH_RET;
               end else begin
                  st <= CH_FWD;
               end
            end
            CH_RET: if (ret_ready) st <= CH_IDLE;
            CH_FWD: if (grant_done) st <= CH_IDLE;
            default: st <= CH_IDLE;
         endcase
      end
   end

   always_comb begin
      m_valid = '0;
      if (st == CH_FWD) m_valid[sel] = 1'b1;
   end

   assign s_ready   = (st == CH_IDLE) && en;
   assign snp_valid = (st == CH_SNOOP);
   assign snp_addr  = m_addr;
   assign ret_valid = (st == CH_RET);
   assign ret_id    = m_id;
endmodule

// File: rtl/cohport_wr_chan.sv
module cohport_wr_chan
   import cohport_pkg::*;
#(
   parameter int NPORT  = 2,
   parameter int ADDR_W = 32,
   parameter int ID_W   = 4,
   localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [ID_W-1:0]   s_id,
   input  axi_attr_t         s_attr,
   input  logic              s_coh_user,
   output logic              snp_valid,
   input  logic              snp_ready,
   output logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_rsp_valid,
   input  logic              snp_rsp_hit,
   input  logic              snp_done,
   output logic [NPORT-1:0]  m_valid,
   input  logic [NPORT-1:0]  m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic [ID_W-1:0]   m_id,
   output axi_attr_t         m_attr
);
   ch_state_e        st;
   logic             en;
   logic             coh;
   logic             pick;
   logic             grant_done;
   logic [SEL_W-1:0] sel;
   logic             accept;

   cohport_classify u_cls (
      .user_bit (s_coh_user),
      .share_bit(s_attr.cache[CACHE_SHARE_BIT]),
      .coherent (coh)
   );

   cohport_port_pick #(.NPORT(NPORT)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (m_ready),
      .pick      (pick),
      .grant_done(grant_done),
      .sel       (sel)
   );

   assign accept     = s_valid && s_ready;
   assign pick       = (accept && !coh) ||
                       (st == CH_WAIT && snp_rsp_valid && !snp_rsp_hit) ||
                       (st == CH_CLEAN && snp_done);
   assign grant_done = (st == CH_FWD) && m_ready[sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= CH_IDLE;
         en     <= 1'b0;
         m_addr <= '0;
         m_id   <= '0;
         m_attr <= '0;
      end else begin
         en <= 1'b1;
         unique case (st)
            CH_IDLE: if (accept) begin
               m_addr      <= s_addr;
               m_id        <= s_id;
               m_attr      <= s_attr;
               m_attr.lock <= 1'b0;
               st          <= coh ? CH_SNOOP : CH_FWD;
            end
            CH_SNOOP: if (snp_ready) st <= CH_WAIT;
            CH_WAIT: if (snp_rsp_valid) st <= snp_rsp_hit ? CH_CLEAN : CH_FWD;
            CH_CLEAN: if (snp_done) st <= CH_FWD;
            CH_FWD: if (grant_done) st <= CH_IDLE;
            default: st <= CH_IDLE;
         endcase
      end
   end

   always_comb begin
      m_valid = '0;
      if (st == CH_FWD) m_valid[sel] = 1'b1;
   end

   assign s_ready   = (st == CH_IDLE) && en;
   assign snp_valid = (st == CH_SNOOP);
   assign snp_addr  = m_addr;
endmodule

// File: rtl/cohport_router.sv
module cohport_router
   import cohport_pkg::*;
#(
   parameter int NPORT        = 2,
   parameter int ADDR_W       = 32,
   parameter int ID_W         = 4,
   parameter int DATA_W       = 32,
   parameter int USER_W       = 1,
   parameter int COH_USER_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic [ID_W-1:0]   s_arid,
   input  logic [3:0]        s_arlen,
   input  logic [2:0]        s_arsize,
   input  logic [1:0]        s_arburst,
   input  logic [3:0]        s_arcache,
   input  logic [2:0]        s_arprot,
   input  logic              s_arlock,
   input  logic [USER_W-1:0] s_aruser,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [ID_W-1:0]   s_rid,
   output logic [1:0]        s_rresp,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic [ID_W-1:0]   s_awid,
   input  logic [3:0]        s_awlen,
   input  logic [2:0]        s_awsize,
   input  logic [1:0]        s_awburst,
   input  logic [3:0]        s_awcache,
   input  logic [2:0]        s_awprot,
   input  logic              s_awlock,
   input  logic [USER_W-1:0] s_awuser,
   output logic              snp_rd_valid,
   input  logic              snp_rd_ready,
   output logic [ADDR_W-1:0] snp_rd_addr,
   input  logic              snp_rd_rsp_valid,
   input  logic              snp_rd_rsp_hit,
   input  logic [DATA_W-1:0] snp_rd_rsp_data,
   output logic              snp_wr_valid,
   input  logic              snp_wr_ready,
   output logic [ADDR_W-1:0] snp_wr_addr,
   input  logic              snp_wr_rsp_valid,
   input  logic              snp_wr_rsp_hit,
   input  logic              snp_wr_done,
   output logic [NPORT-1:0]  m_arvalid,
   input  logic [NPORT-1:0]  m_arready,
   output logic [ADDR_W-1:0] m_araddr,
   output logic [ID_W-1:0]   m_arid,
   output logic [3:0]        m_arlen,
   output logic [2:0]        m_arsize,
   output logic [1:0]        m_arburst,
   output logic [3:0]        m_arcache,
   output logic [2:0]        m_arprot,
   output logic              m_arlock,
   output logic [NPORT-1:0]  m_awvalid,
   input  logic [NPORT-1:0]  m_awready,
   output logic [ADDR_W-1:0] m_awaddr,
   output logic [ID_W-1:0]   m_awid,
   output logic [3:0]        m_awlen,
   output logic [2:0]        m_awsize,
   output logic [1:0]        m_awburst,
   output logic [3:0]        m_awcache,
   output logic [2:0]        m_awprot,
   output logic              m_awlock
);
   localparam logic [1:0] RESP_OKAY = 2'b00;

   if (COH_USER_BIT >= USER_W || COH_USER_BIT < 0) begin : g_user_chk
      $error("COH_USER_BIT lies outside the user field");
   end
   if (ADDR_W < 1 || ID_W < 1 || DATA_W < 1) begin : g_width_chk
      $error("cohport_router widths must be positive");
   end

   axi_attr_t ar_in, aw_in, ar_out, aw_out;

   assign ar_in = '{len: s_arlen, size: s_arsize, burst: s_arburst,
                    cache: s_arcache, prot: s_arprot, lock: s_arlock};
   assign aw_in = '{len: s_awlen, size: s_awsize, burst: s_awburst,
                    cache: s_awcache, prot: s_awprot, lock: s_awlock};

   cohport_rd_chan #(.NPORT(NPORT), .ADDR_W(ADDR_W), .ID_W(ID_W),
                     .DATA_W(DATA_W)) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .s_valid      (s_arvalid),
      .s_ready      (s_arready),
      .s_addr       (s_araddr),
      .s_id         (s_arid),
      .s_attr       (ar_in),
      .s_coh_user   (s_aruser[COH_USER_BIT]),
      .ret_valid    (s_rvalid),
      .ret_ready    (s_rready),
      .ret_data     (s_rdata),
      .ret_id       (s_rid),
      .snp_valid    (snp_rd_valid),
      .snp_ready    (snp_rd_ready),
      .snp_addr     (snp_rd_addr),
      .snp_rsp_valid(snp_rd_rsp_valid),
      .snp_rsp_hit  (snp_rd_rsp_hit),
      .snp_rsp_data (snp_rd_rsp_data),
      .m_valid      (m_arvalid),
      .m_ready      (m_arready),
      .m_addr       (m_araddr),
      .m_id         (m_arid),
      .m_attr       (ar_out)
   );

   cohport_wr_chan #(.NPORT(NPORT), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_wr (
      .clk          (clk),
      .rst_n        (rst_n),
      .s_valid      (s_awvalid),
      .s_ready      (s_awready),
      .s_addr       (s_awaddr),
      .s_id         (s_awid),
      .s_attr       (aw_in),
      .s_coh_user   (s_awuser[COH_USER_BIT]),
      .snp_valid    (snp_wr_valid),
      .snp_ready    (snp_wr_ready),
      .snp_addr     (snp_wr_addr),
      .snp_rsp_valid(snp_wr_rsp_valid),
      .snp_rsp_hit  (snp_wr_rsp_hit),
      .snp_done     (snp_wr_done),
      .m_valid      (m_awvalid),
      .m_ready      (m_awready),
      .m_addr       (m_awaddr),
      .m_id         (m_awid),
      .m_attr       (aw_out)
   );

   assign s_rresp   = RESP_OKAY;
   assign m_arlen   = ar_out.len;
   assign m_arsize  = ar_out.size;
   assign m_arburst = ar_out.burst;
   assign m_arcache = ar_out.cache;
   assign m_arprot  = ar_out.prot;
   assign m_arlock  = ar_out.lock;
   assign m_awlen   = aw_out.len;
   assign m_awsize  = aw_out.size;
   assign m_awburst = aw_out.burst;
   assign m_awcache = aw_out.cache;
   assign m_awprot  = aw_out.prot;
   assign m_awlock  = aw_out.lock;
endmodule

// File: rtl/cohport_router_chk.sv
module cohport_router_chk #(
   parameter int NPORT        = 2,
   parameter int ADDR_W       = 32,
   parameter int ID_W         = 4,
   parameter int DATA_W       = 32,
   parameter int USER_W       = 1,
   parameter int COH_USER_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_arvalid,
   input logic              s_arready,
   input logic [3:0]        s_arcache,
   input logic [USER_W-1:0] s_aruser,
   input logic              s_awvalid,
   input logic              s_awready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [DATA_W-1:0] s_rdata,
   input logic [ID_W-1:0]   s_rid,
   input logic              snp_rd_valid,
   input logic              snp_wr_rsp_valid,
   input logic              snp_wr_rsp_hit,
   input logic              snp_wr_done,
   input logic [NPORT-1:0]  m_arvalid,
   input logic [NPORT-1:0]  m_arready,
   input logic [ADDR_W-1:0] m_araddr,
   input logic [NPORT-1:0]  m_awvalid,
   input logic [NPORT-1:0]  m_awready,
   input logic [ADDR_W-1:0] m_awaddr
);
   logic clean_pend;

   always_ff @(posedge clk) begin
      if (!rst_n)
         clean_pend <= 1'b0;
      else if (snp_wr_rsp_valid && snp_wr_rsp_hit)
         clean_pend <= 1'b1;
      else if (snp_wr_done)
         clean_pend <= 1'b0;
   end

   a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      (s_arvalid && s_arready) |=> !s_arready);

   a_r9_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_awready) |=> !s_awready);

   a_r3_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      (s_arvalid && s_arready && !(s_aruser[COH_USER_BIT] && s_arcache[1]))
      |=> !snp_rd_valid);

   a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rid)));

   a_r4_no_fwd_on_return: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid |-> (m_arvalid == '0));

   a_r7_clean_first: assert property (@(posedge clk) disable iff (!rst_n)
      clean_pend |-> (m_awvalid == '0));

   a_r12_ar_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_arvalid));

   a_r12_aw_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_awvalid));

   a_r12_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (|(m_arvalid & ~m_arready)) |=> ($stable(m_arvalid) && $stable(m_araddr)));

   a_r12_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (|(m_awvalid & ~m_awready)) |=> ($stable(m_awvalid) && $stable(m_awaddr)));
endmodule

bind cohport_router cohport_router_chk #(
   .NPORT(NPORT), .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W),
   .USER_W(USER_W), .COH_USER_BIT(COH_USER_BIT)
) u_chk (.*);

// File: tb/cohport_router_bench.sv
`timescale 1ns/1ps
module cohport_router_bench;
   localparam int NPORT  = 2;
   localparam int ADDR_W = 16;
   localparam int ID_W   = 3;
   localparam int DATA_W = 32;
   localparam int USER_W = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              s_arvalid = 0, s_arready;
   logic [ADDR_W-1:0] s_araddr = 0;
   logic [ID_W-1:0]   s_arid = 0;
   logic [3:0]        s_arlen = 0, s_arcache = 0;
   logic [2:0]        s_arsize = 0, s_arprot = 0;
   logic [1:0]        s_arburst = 0;
   logic              s_arlock = 0;
   logic [USER_W-1:0] s_aruser = 0;
   logic              s_rvalid, s_rready = 0;
   logic [DATA_W-1:0] s_rdata;
   logic [ID_W-1:0]   s_rid;
   logic [1:0]        s_rresp;
   logic              s_awvalid = 0, s_awready;
   logic [ADDR_W-1:0] s_awaddr = 0;
   logic [ID_W-1:0]   s_awid = 0;
   logic [3:0]        s_awlen = 0, s_awcache = 0;
   logic [2:0]        s_awsize = 0, s_awprot = 0;
   logic [1:0]        s_awburst = 0;
   logic              s_awlock = 0;
   logic [USER_W-1:0] s_awuser = 0;
   logic              snp_rd_valid, snp_rd_ready = 1;
   logic [ADDR_W-1:0] snp_rd_addr;
   logic              snp_rd_rsp_valid = 0, snp_rd_rsp_hit = 0;
   logic [DATA_W-1:0] snp_rd_rsp_data = 0;
   logic              snp_wr_valid, snp_wr_ready = 1;
   logic [ADDR_W-1:0] snp_wr_addr;
   logic              snp_wr_rsp_valid = 0, snp_wr_rsp_hit = 0, snp_wr_done = 0;
   logic [NPORT-1:0]  m_arvalid, m_awvalid;
   logic [NPORT-1:0]  m_arready = 2'b11, m_awready = 2'b11;
   logic [ADDR_W-1:0] m_araddr, m_awaddr;
   logic [ID_W-1:0]   m_arid, m_awid;
   logic [3:0]        m_arlen, m_arcache, m_awlen, m_awcache;
   logic [2:0]        m_arsize, m_arprot, m_awsize, m_awprot;
   logic [1:0]        m_arburst, m_awburst;
   logic              m_arlock, m_awlock;

   cohport_router #(.NPORT(NPORT), .ADDR_W(ADDR_W), .ID_W(ID_W),
                    .DATA_W(DATA_W), .USER_W(USER_W)) u_cohport_router (.*);

   int total = 0, bad = 0;
   bit ended = 0;
   logic rd_hit = 0, wr_hit = 0;
   logic [ADDR_W-1:0] rd_snp_seen = 0, wr_snp_seen = 0;
   int rd_snoops = 0, wr_snoops = 0, cleans = 0;
   int rd_ptr = 0, wr_ptr = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic logic [DATA_W-1:0] snp_word(input logic [ADDR_W-1:0] a);
      return {16'hC0DE, a ^ 16'h5A5A};
   endfunction

   always @(posedge clk) begin
      if (rst_n && snp_rd_valid && snp_rd_ready) rd_snoops++;
      if (rst_n && snp_wr_valid && snp_wr_ready) wr_snoops++;
      if (rst_n && snp_wr_done) cleans++;
   end

   // snoop read responder
   initial forever begin
      @(negedge clk);
      if (rst_n && snp_rd_valid) begin
         rd_snp_seen = snp_rd_addr;
         @(negedge clk);
         snp_rd_rsp_valid = 1;
         snp_rd_rsp_hit   = rd_hit;
         snp_rd_rsp_data  = snp_word(rd_snp_seen);
         @(negedge clk);
         snp_rd_rsp_valid = 0;
         snp_rd_rsp_hit   = 0;
      end
   end

   // snoop write responder with clean completion
   initial forever begin
      @(negedge clk);
      if (rst_n && snp_wr_valid) begin
         wr_snp_seen = snp_wr_addr;
         @(negedge clk);
         snp_wr_rsp_valid = 1;
         snp_wr_rsp_hit   = wr_hit;
         @(negedge clk);
         snp_wr_rsp_valid = 0;
         snp_wr_rsp_hit   = 0;
         if (wr_hit) begin
            repeat (2) @(negedge clk);
            snp_wr_done = 1;
            @(negedge clk);
            snp_wr_done = 0;
         end
      end
   end

   function automatic int pick_port(input int ptr, input logic [1:0] rdy);
      if (rdy[ptr] || !rdy[1-ptr]) return ptr;
      return 1 - ptr;
   endfunction

   task automatic do_read(input logic [ADDR_W-1:0] addr, input logic [ID_W-1:0] id,
                          input logic u, input logic [3:0] cache, input logic hit);
      logic coh;
      bit seen;
      int ep;
      string rq;
      coh = u & cache[1];
      rd_hit = hit;
      rd_snoops = 0;
      @(negedge clk);
      s_arvalid = 1; s_araddr = addr; s_arid = id; s_arlen = ~cache;
      s_arsize = {1'b0, cache[1:0]}; s_arburst = cache[3:2]; s_arcache = cache;
      s_arprot = id; s_arlock = 1; s_aruser = u;
      while (!s_arready) @(negedge clk);
      @(negedge clk);
      s_arvalid = 0;
      check(s_arready == 0, "R9", "arready low after accept", s_arready, 0);
      seen = 0;
      for (int k = 0; k < 40 && !seen; k++) begin
         if (s_rvalid || (m_arvalid != 0)) seen = 1;
         else @(negedge clk);
      end
      check(seen, "R3", "read produced an outcome", seen, 1);
      rq = coh ? "R2" : "R3";
      check(rd_snoops == int'(coh), rq, "read snoop count", rd_snoops, coh);
      if (coh) check(rd_snp_seen == addr, "R2", "snoop address", rd_snp_seen, addr);
      if (coh && hit) begin
         check(s_rvalid && m_arvalid == 0, "R4", "hit returns without forward",
               {s_rvalid, m_arvalid}, 3'b100);
         check(s_rdata == snp_word(addr), "R4", "rdata", s_rdata, snp_word(addr));
         check(s_rid == id && s_rresp == 2'b00, "R4", "rid/rresp",
               {s_rid, s_rresp}, {id, 2'b00});
         @(negedge clk);
         check(s_rvalid && s_rdata == snp_word(addr), "R4", "rdata held",
               s_rvalid, 1);
         s_rready = 1;
         @(negedge clk);
         s_rready = 0;
         check(!s_rvalid && s_arready, "R9", "read channel free after return",
               {s_rvalid, s_arready}, 2'b01);
      end else begin
         ep = pick_port(rd_ptr, m_arready);
         rq = (m_arready == 2'b11) ? "R10" : "R11";
         check(m_arvalid == (2'b01 << ep), rq, "read port", m_arvalid, 2'b01 << ep);
         check(m_araddr == addr && m_arid == id && m_arlen == ~cache &&
               m_arsize == {1'b0, cache[1:0]} && m_arburst == cache[3:2] &&
               m_arcache == cache && m_arprot == id, "R5", "read fields",
               {m_araddr, m_arid, m_arcache}, {addr, id, cache});
         check(m_arlock == 0, "R5", "read lock cleared", m_arlock, 0);
         if (m_arready == 2'b00) begin
            for (int k = 0; k < 3; k++) begin
               @(negedge clk);
               check(m_arvalid == (2'b01 << ep) && m_araddr == addr, "R12",
                     "stalled read held", m_arvalid, 2'b01 << ep);
            end
            m_arready = 2'b11;
         end
         @(negedge clk);
         check(m_arvalid == 0 && s_arready, "R9", "read channel free after forward",
               {m_arvalid, s_arready}, 3'b001);
         rd_ptr = 1 - ep;
      end
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] addr, input logic [ID_W-1:0] id,
                           input logic u, input logic [3:0] cache, input logic hit);
      logic coh;
      bit seen;
      int ep;
      string rq;
      coh = u & cache[1];
      wr_hit = hit;
      wr_snoops = 0;
      cleans = 0;
      @(negedge clk);
      s_awvalid = 1; s_awaddr = addr; s_awid = id; s_awlen = cache;
      s_awsize = {cache[0], 2'b01}; s_awburst = cache[2:1]; s_awcache = cache;
      s_awprot = ~id; s_awlock = 1; s_awuser = u;
      while (!s_awready) @(negedge clk);
      @(negedge clk);
      s_awvalid = 0;
      check(s_awready == 0, "R9", "awready low after accept", s_awready, 0);
      seen = 0;
      for (int k = 0; k < 40 && !seen; k++) begin
         if (m_awvalid != 0) seen = 1;
         else @(negedge clk);
      end
      check(seen, "R8", "write forwarded", seen, 1);
      check(wr_snoops == int'(coh), "R6", "write snoop count", wr_snoops, coh);
      if (coh) check(wr_snp_seen == addr, "R6", "write snoop address", wr_snp_seen, addr);
      check(cleans == int'(coh && hit), "R7", "clean done before forward",
            cleans, coh && hit);
      ep = pick_port(wr_ptr, m_awready);
      rq = (m_awready == 2'b11) ? "R10" : "R11";
      check(m_awvalid == (2'b01 << ep), rq, "write port", m_awvalid, 2'b01 << ep);
      check(m_awaddr == addr && m_awid == id && m_awlen == cache &&
            m_awsize == {cache[0], 2'b01} && m_awburst == cache[2:1] &&
            m_awcache == cache && m_awprot == ~id, "R8", "write fields",
            {m_awaddr, m_awid, m_awcache}, {addr, id, cache});
      check(m_awlock == 0, "R8", "write lock cleared", m_awlock, 0);
      if (m_awready == 2'b00) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(m_awvalid == (2'b01 << ep) && m_awaddr == addr, "R12",
                  "stalled write held", m_awvalid, 2'b01 << ep);
         end
         m_awready = 2'b11;
      end
      @(negedge clk);
      check(m_awvalid == 0 && s_awready, "R9", "write channel free after forward",
            {m_awvalid, s_awready}, 3'b001);
      wr_ptr = 1 - ep;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(s_arready == 0 && s_awready == 0, "R1", "readies in reset",
            {s_arready, s_awready}, 0);
      check(!s_rvalid && !snp_rd_valid && !snp_wr_valid && m_arvalid == 0 &&
            m_awvalid == 0, "R1", "valids in reset",
            {s_rvalid, snp_rd_valid, snp_wr_valid, m_arvalid, m_awvalid}, 0);
      rst_n = 1;
      @(negedge clk);
      check(s_arready && s_awready, "R1", "readies after reset",
            {s_arready, s_awready}, 2'b11);

      // classification sweep, hit chosen by cache bit 0
      for (int u = 0; u < 2; u++)
         for (int c = 0; c < 16; c++)
            do_read(ADDR_W'(16'h0100 + u * 256 + c * 4), ID_W'(c), u[0], 4'(c), c[0]);
      for (int u = 0; u < 2; u++)
         for (int c = 0; c < 16; c++)
            do_write(ADDR_W'(16'h2000 + u * 256 + c * 8), ID_W'(c + 1), u[0], 4'(c), c[0]);

      // port skip and stall cases
      foreach (m_arready[i]) begin end
      m_arready = 2'b01; do_read(16'h3000, 3'd1, 1'b0, 4'h0, 1'b0);
      m_arready = 2'b01; do_read(16'h3004, 3'd2, 1'b0, 4'h0, 1'b0);
      m_arready = 2'b10; do_read(16'h3008, 3'd3, 1'b1, 4'h2, 1'b0);
      m_arready = 2'b10; do_read(16'h300C, 3'd4, 1'b0, 4'h3, 1'b0);
      m_arready = 2'b00; do_read(16'h3010, 3'd5, 1'b0, 4'h1, 1'b0);
      m_arready = 2'b00; do_read(16'h3014, 3'd6, 1'b1, 4'h6, 1'b0);
      m_awready = 2'b10; do_write(16'h4000, 3'd1, 1'b0, 4'h0, 1'b0);
      m_awready = 2'b01; do_write(16'h4008, 3'd2, 1'b1, 4'h2, 1'b0);
      m_awready = 2'b01; do_write(16'h4010, 3'd3, 1'b0, 4'h4, 1'b0);
      m_awready = 2'b00; do_write(16'h4018, 3'd4, 1'b1, 4'h3, 1'b1);
      m_awready = 2'b00; do_write(16'h4020, 3'd5, 1'b0, 4'h8, 1'b0);
      m_arready = 2'b11; m_awready = 2'b11;
      do_read(16'h5000, 3'd7, 1'b1, 4'hF, 1'b1);
      do_write(16'h5008, 3'd7, 1'b1, 4'hF, 1'b1);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule